// File: doc/BRIEF.md
# Triggered Trace Capture Controller

This block sits beside a processor pipeline and turns its execution stream into a trace history. Each cycle that the core reports as valid can become one entry in an external circular trace memory. The controller drives that memory's write port and tracks the next write address and how many entries are held. It also decides when recording must freeze and whether the processor must be stopped. A separate event matcher supplies a single-cycle trigger pulse. The controller notes the first such pulse after arming, together with the address its entry went to, so that a later readout can mark the triggering cycle.

Four capture modes are selected by a two-bit configuration field. Free-running mode records into a wrapping window with no halt. Halt-at-trigger mode freezes with the trigger cycle as the newest entry. Delayed-halt mode keeps recording for a programmed number of cycles past the trigger before it halts. Fill-and-halt mode never overwrites: it stops once the memory holds one entry less than its depth. Forced no-op cycles can optionally be taken out of event processing. These are the second half of a two-cycle instruction, or a prefetch that was thrown away after a jump. A second bit decides whether such filtered cycles are still written. A synchronous arm input clears the controller for a fresh run.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, or in the cycle after `arm` is high, `halt_req`, `triggered`, `stopped` and `mem_we` are 0 and `wr_ptr` and `entry_count` are 0. A cycle presented while `arm` is high is not recorded.
- R2: An accepted cycle that is written shows `mem_we`=1 one clock later, with `mem_addr` equal to the write pointer before the write and `mem_wdata` equal to the presented data. `wr_ptr` then advances by one modulo the depth, and `entry_count` rises by one and saturates at the depth.
- R3: With `cfg_mode`=0 (free-running), writes wrap around the memory and `stopped` and `halt_req` stay 0. A trigger still sets `triggered`.
- R4: With `cfg_mode`=1 (halt at trigger), the trigger cycle is the last entry written. `halt_req` and `stopped` rise in the same clock as that entry's `mem_we`.
- R5: With `cfg_mode`=2 (delayed halt), after the trigger entry exactly `cfg_post_cycles` further counted cycles are written. `halt_req` and `stopped` rise with the last of them. A value of 0 behaves like R4.
- R6: With `cfg_mode`=3 (fill and halt), the memory does not wrap. The write that brings `entry_count` to depth-1 raises `halt_req` and `stopped`, and a trigger does not stop capture.
- R7: When `cfg_ign_fnop`=1, a cycle with `cyc_fnop`=1 can neither trigger nor advance the post-trigger count. It is written only if `cfg_keep_fnop`=1. When `cfg_ign_fnop`=0, such cycles are treated like any other.
- R8: `trig_addr` holds the address of the entry written for the honoured trigger. Only the first qualifying trigger after arming is honoured, and later pulses leave `trig_addr` unchanged.
- R9: `halt_req` and `stopped` stay set until arm or reset. No write occurs while `stopped` is 1.
- R10: A cycle with `cyc_valid`=0 writes nothing and leaves the pointer, the count and the trigger state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Synchronous clear and re-arm for a new run |
| cfg_mode | input | 2 | Capture mode: 0 free, 1 halt at trigger, 2 delayed halt, 3 fill and halt |
| cfg_post_cycles | input | CW | Counted cycles recorded after the trigger in mode 2 |
| cfg_ign_fnop | input | 1 | Remove forced no-op cycles from event processing |
| cfg_keep_fnop | input | 1 | Still write forced no-op cycles that are removed |
| cyc_valid | input | 1 | An execution cycle is presented |
| cyc_data | input | DW | Trace word for the cycle |
| cyc_fnop | input | 1 | The cycle is a forced no-op |
| trig_evt | input | 1 | Trigger pulse from the event matcher |
| mem_we | output | 1 | Trace memory write enable |
| mem_addr | output | AW | Trace memory write address |
| mem_wdata | output | DW | Trace memory write data |
| halt_req | output | 1 | Sticky processor halt request |
| triggered | output | 1 | A trigger has been honoured since arming |
| stopped | output | 1 | Capture is frozen |
| entry_count | output | AW+1 | Entries held, saturating at the depth |
| wr_ptr | output | AW | Address of the next write |
| trig_addr | output | AW | Address of the trigger entry |

## Verification
The trigger and the fill limit can land on the same write in fill-and-halt mode. In that cycle the controller must latch the trigger address and raise the halt. The bench provokes this by filling the memory to one short of the limit and then presenting a trigger on the filling cycle. It then expects `triggered`, `trig_addr` at depth-2, `halt_req`, `stopped` and `entry_count` at depth-1 after that one edge, and no write on the following cycle. A second overlap, a trigger pulse on a filtered forced no-op, is judged by showing that no trigger is latched and that the count does not move.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    TRC_FREE      = 2'd0,
    TRC_HALT_TRIG = 2'd1,
    TRC_HALT_POST = 2'd2,
    TRC_HALT_FULL = 2'd3
  } trc_mode_e;

endpackage

// File: rtl/trc_cycle_qual.sv
// Classifies the presented cycle: written, counted as an event, honoured trigger.
module trc_cycle_qual (
  input  logic cyc_valid,
  input  logic cyc_fnop,
  input  logic trig_evt,
  input  logic cfg_ign_fnop,
  input  logic cfg_keep_fnop,
  input  logic capture_on,
  input  logic trig_armed,
  output logic wr_go,
  output logic evt_go,
  output logic trig_go
);

  logic fnop_drop;
  logic accepted;

  always_comb begin
    fnop_drop = cfg_ign_fnop & cyc_fnop;
    accepted  = cyc_valid & capture_on;
    evt_go    = accepted & ~fnop_drop;
    wr_go     = accepted & (~fnop_drop | cfg_keep_fnop);
    trig_go   = evt_go & trig_evt & trig_armed;
  end

endmodule

// File: rtl/trc_wr_track.sv
// Registered write port, write pointer and saturating entry count.
module trc_wr_track #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_go,
  input  logic [DW-1:0] wr_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic [AW:0]   entry_count,
  output logic          at_limit
);

  localparam int          DEPTH     = 1 << AW;
  localparam logic [AW:0] CNT_SAT   = (AW+1)'(DEPTH);
  localparam logic [AW:0] PRE_LIMIT = (AW+1)'(DEPTH - 2);

  // next write is the one that reaches depth-1 entries
  assign at_limit = (entry_count == PRE_LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      wr_ptr      <= '0;
      entry_count <= '0;
    end else begin
      mem_we <= wr_go;
      if (wr_go) begin
        mem_addr  <= wr_ptr;
        mem_wdata <= wr_data;
        wr_ptr    <= wr_ptr + 1'b1;
        if (entry_count != CNT_SAT) begin
          entry_count <= entry_count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trc_stop_ctl.sv
// Trigger latch, post-trigger counter and stop/halt decision.
module trc_stop_ctl
  import trc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  trc_mode_e     mode,
  input  logic [CW-1:0] post_cycles,
  input  logic          wr_go,
  input  logic          evt_go,
  input  logic          trig_go,
  input  logic          at_limit,
  input  logic [AW-1:0] wr_ptr,
  output logic          triggered,
  output logic [AW-1:0] trig_addr,
  output logic          stopped,
  output logic          halt_req
);

  localparam logic [CW-1:0] POST_MAX = '1;

  logic [CW-1:0] post_cnt;
  logic [CW-1:0] post_nxt;
  logic          post_step;
  logic          stop_now;

  always_comb begin
    post_step = triggered & evt_go;
    post_nxt  = post_cnt + 1'b1;
    unique case (mode)
      TRC_HALT_TRIG: stop_now = trig_go;
      TRC_HALT_POST: stop_now = (trig_go && post_cycles == '0) ||
                                (post_step && post_nxt == post_cycles);
      TRC_HALT_FULL: stop_now = wr_go & at_limit;
      default:       stop_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      triggered <= 1'b0;
      trig_addr <= '0;
      post_cnt  <= '0;
      stopped   <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      if (trig_go) begin
        triggered <= 1'b1;
        trig_addr <= wr_ptr;
        post_cnt  <= '0;
      end else if (post_step && post_cnt != POST_MAX) begin
        post_cnt <= post_nxt;
      end
      if (stop_now) begin
        stopped  <= 1'b1;
        halt_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_post_cycles,
  input  logic          cfg_ign_fnop,
  input  logic          cfg_keep_fnop,
  input  logic          cyc_valid,
  input  logic [DW-1:0] cyc_data,
  input  logic          cyc_fnop,
  input  logic          trig_evt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          halt_req,
  output logic          triggered,
  output logic          stopped,
  output logic [AW:0]   entry_count,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] trig_addr
);

  logic wr_go;
  logic evt_go;
  logic trig_go;
  logic at_limit;
  logic capture_on;
  logic trig_armed;

  assign capture_on = ~stopped & ~arm;
  assign trig_armed = ~triggered;

  trc_cycle_qual u_qual (
    .cyc_valid     (cyc_valid),
    .cyc_fnop      (cyc_fnop),
    .trig_evt      (trig_evt),
    .cfg_ign_fnop  (cfg_ign_fnop),
    .cfg_keep_fnop (cfg_keep_fnop),
    .capture_on    (capture_on),
    .trig_armed    (trig_armed),
    .wr_go         (wr_go),
    .evt_go        (evt_go),
    .trig_go       (trig_go)
  );

  trc_wr_track #(.DW(DW), .AW(AW)) u_wr (
    .clk         (clk),
    .rst         (rst),
    .clr         (arm),
    .wr_go       (wr_go),
    .wr_data     (cyc_data),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .wr_ptr      (wr_ptr),
    .entry_count (entry_count),
    .at_limit    (at_limit)
  );

  trc_stop_ctl #(.AW(AW), .CW(CW)) u_stop (
    .clk         (clk),
    .rst         (rst),
    .clr         (arm),
    .mode        (trc_mode_e'(cfg_mode)),
    .post_cycles (cfg_post_cycles),
    .wr_go       (wr_go),
    .evt_go      (evt_go),
    .trig_go     (trig_go),
    .at_limit    (at_limit),
    .wr_ptr      (wr_ptr),
    .triggered   (triggered),
    .trig_addr   (trig_addr),
    .stopped     (stopped),
    .halt_req    (halt_req)
  );

endmodule

// File: rtl/trc_checks.sv
module trc_checks #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic [1:0]    cfg_mode,
  input logic          mem_we,
  input logic          halt_req,
  input logic          triggered,
  input logic          stopped,
  input logic [AW:0]   entry_count,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] trig_addr
);

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!halt_req && !triggered && !stopped && !mem_we &&
             wr_ptr == '0 && entry_count == '0));                      // R1

  AST_FREE_NO_HALT: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req) |-> $past(cfg_mode) != 2'd0);                      // R3

  AST_TRIG_ONCE: assert property (@(posedge clk) disable iff (rst)
    (triggered && !arm) |=> (triggered && $stable(trig_addr)));        // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !arm) |=> halt_req);                                  // R9

  AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    stopped |=> !mem_we);                                              // R9

  AST_HALT_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> stopped);                                             // R4

endmodule

bind trace_capture_ctrl trc_checks #(.AW(AW)) u_trc_checks (
  .clk         (clk),
  .rst         (rst),
  .arm         (arm),
  .cfg_mode    (cfg_mode),
  .mem_we      (mem_we),
  .halt_req    (halt_req),
  .triggered   (triggered),
  .stopped     (stopped),
  .entry_count (entry_count),
  .wr_ptr      (wr_ptr),
  .trig_addr   (trig_addr)
);

// File: tb/tb_trace_capture_ctrl.sv
`timescale 1ns/100ps
module tb_trace_capture_ctrl;

  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          arm;
  logic [1:0]    cfg_mode;
  logic [CW-1:0] cfg_post_cycles;
  logic          cfg_ign_fnop;
  logic          cfg_keep_fnop;
  logic          cyc_valid;
  logic [DW-1:0] cyc_data;
  logic          cyc_fnop;
  logic          trig_evt;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          halt_req;
  logic          triggered;
  logic          stopped;
  logic [AW:0]   entry_count;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] trig_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  trace_capture_ctrl #(.DW(DW), .AW(AW), .CW(CW)) dut (.*);

  // stimulus {arm,valid,fnop,trig,data[7:0]} ; expected {we,addr[2:0],halt,trg,stop,ptr[2:0]}
  // mode 2, post count 2, forced no-ops filtered and dropped
  localparam logic [21:0] VEC [10] = '{
    {1'b0,1'b1,1'b0,1'b0,8'hA0, 1'b1,3'd0,1'b0,1'b0,1'b0,3'd1},
    {1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b0,1'b0,1'b0,3'd1},
    {1'b0,1'b1,1'b1,1'b1,8'hA2, 1'b0,3'd0,1'b0,1'b0,1'b0,3'd1},
    {1'b0,1'b1,1'b0,1'b1,8'hA3, 1'b1,3'd1,1'b0,1'b1,1'b0,3'd2},
    {1'b0,1'b1,1'b0,1'b1,8'hA4, 1'b1,3'd2,1'b0,1'b1,1'b0,3'd3},
    {1'b0,1'b1,1'b1,1'b0,8'hA5, 1'b0,3'd0,1'b0,1'b1,1'b0,3'd3},
    {1'b0,1'b1,1'b0,1'b0,8'hA6, 1'b1,3'd3,1'b1,1'b1,1'b1,3'd4},
    {1'b0,1'b1,1'b0,1'b0,8'hA7, 1'b0,3'd0,1'b1,1'b1,1'b1,3'd4},
    {1'b1,1'b1,1'b0,1'b1,8'hA8, 1'b0,3'd0,1'b0,1'b0,1'b0,3'd0},
    {1'b0,1'b1,1'b0,1'b0,8'hA9, 1'b1,3'd0,1'b0,1'b0,1'b0,3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, step one rising edge, return at the next falling edge
  task automatic step(input logic a, input logic v, input logic f, input logic t,
                      input logic [DW-1:0] d);
    arm = a; cyc_valid = v; cyc_fnop = f; trig_evt = t; cyc_data = d;
    @(posedge clk);
    @(negedge clk);
    arm = 1'b0; cyc_valid = 1'b0; cyc_fnop = 1'b0; trig_evt = 1'b0;
  endtask

  task automatic rearm(input logic [1:0] m, input logic [CW-1:0] n,
                       input logic ign, input logic keep);
    cfg_mode = m; cfg_post_cycles = n; cfg_ign_fnop = ign; cfg_keep_fnop = keep;
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; arm = 1'b0; cyc_valid = 1'b0; cyc_fnop = 1'b0; trig_evt = 1'b0;
    cyc_data = '0; cfg_mode = 2'd2; cfg_post_cycles = 4'd2;
    cfg_ign_fnop = 1'b1; cfg_keep_fnop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset halt", halt_req, 0);
    chk("R1 reset triggered", triggered, 0);
    chk("R1 reset stopped", stopped, 0);
    chk("R1 reset ptr", wr_ptr, 0);
    chk("R1 reset count", entry_count, 0);

    // vector table: R2 R5 R7 R8 R10, arm row R1
    for (int i = 0; i < 10; i++) begin
      logic [21:0] vv;
      vv = VEC[i];
      step(vv[21], vv[20], vv[19], vv[18], vv[17:10]);
      chk("R2 R7 R10 vec mem_we", mem_we, vv[9]);
      if (vv[9]) begin
        chk("R2 vec addr", mem_addr, vv[8:6]);
        chk("R2 vec data", mem_wdata, vv[17:10]);
      end
      chk("R5 R9 vec halt", halt_req, vv[5]);
      chk("R8 R1 vec triggered", triggered, vv[4]);
      chk("R5 vec stopped", stopped, vv[3]);
      chk("R2 vec ptr", wr_ptr, vv[2:0]);
    end

    // R4 halt at trigger; trigger on a forced no-op with filtering off (R7)
    rearm(2'd1, 4'd0, 1'b0, 1'b0);
    chk("R1 arm clears ptr", wr_ptr, 0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h10 + 8'(i));
    chk("R4 no halt before trigger", halt_req, 0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h55);
    chk("R7 fnop unfiltered triggers", triggered, 1);
    chk("R4 trigger entry written", mem_we, 1);
    chk("R4 trigger entry addr", mem_addr, 3);
    chk("R4 trigger entry data", mem_wdata, 8'h55);
    chk("R4 halt with last entry", halt_req, 1);
    chk("R4 stopped with last entry", stopped, 1);
    chk("R8 trig_addr", trig_addr, 3);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h66);
    chk("R9 no write after stop", mem_we, 0);
    chk("R9 halt sticky", halt_req, 1);
    chk("R9 ptr frozen", wr_ptr, 4);

    // R5 zero post count acts like halt at trigger
    rearm(2'd2, 4'd0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h20);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h21);
    chk("R5 zero post halt", halt_req, 1);
    chk("R5 zero post addr", mem_addr, 1);
    chk("R5 zero post we", mem_we, 1);

    // R6 fill and halt, trigger on the filling write
    rearm(2'd3, 4'd0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h30 + 8'(i));
    chk("R6 not yet stopped", stopped, 0);
    chk("R6 count six", entry_count, 6);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h3F);
    chk("R7 filtered fnop no trigger", triggered, 0);
    chk("R7 filtered fnop no count", entry_count, 6);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h40);
    chk("R6 filling write addr", mem_addr, 6);
    chk("R6 halt at limit", halt_req, 1);
    chk("R6 count at limit", entry_count, 7);
    chk("R8 trig_addr at limit", trig_addr, 6);
    chk("R6 triggered on fill", triggered, 1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h41);
    chk("R6 no wrap write", mem_we, 0);
    chk("R6 ptr held", wr_ptr, 7);

    // R3 free-running wrap, second trigger ignored (R8)
    rearm(2'd0, 4'd0, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++)
      step(1'b0, 1'b1, 1'b0, (i == 1 || i == 5), 8'h50 + 8'(i));
    chk("R3 wrap ptr", wr_ptr, 2);
    chk("R2 count saturates", entry_count, 8);
    chk("R3 no halt", halt_req, 0);
    chk("R3 no stop", stopped, 0);
    chk("R3 triggered", triggered, 1);
    chk("R8 first trigger kept", trig_addr, 1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R10 idle no write", mem_we, 0);
    chk("R10 idle ptr", wr_ptr, 2);

    // R7 filtered but kept forced no-op
    rearm(2'd1, 4'd0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h70);
    chk("R7 kept fnop written", mem_we, 1);
    chk("R7 kept fnop no trigger", triggered, 0);
    chk("R7 kept fnop no halt", halt_req, 0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h71);
    chk("R7 real trigger halts", halt_req, 1);
    chk("R8 trig_addr after kept", trig_addr, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule